// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the bus interface of a parallel NOR flash that follows the common single-supply command set. Each latched bus write reaches it as one cycle of `wr_valid_i`, carrying an address and a data byte. The block checks those writes against the multi-cycle unlock sequences. When a sequence completes, it issues a single-cycle operation request to the embedded-algorithm controller. The controller reports completion on `op_done_i`. It raises `op_timeout_i` when an operation has run past its time limit.

The block follows the operating mode: array read, autoselect, busy or erase-suspended. It collects sector-erase selections during a timed acceptance window. While an operation runs, it filters commands: only erase suspend is honoured during a sector erase, and reset is honoured only when the timeout flag is raised. The window length is a cycle count derived from the clock frequency. This lets a test use a short window.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (array read), `req_valid_o` is low and `erase_set_o` is all zero. The mode encoding is 0 array read, 1 autoselect, 2 busy and 3 erase-suspended.
- R2: Every command sequence opens with AAh at address 555h, then 55h at 2AAh. Only address bits 10..0 are compared. Any other write at a sequence step ends the sequence and returns to the base mode without a request. The base mode is array read, or erase-suspended while suspended.
- R3: After the unlock pair, A0h at 555h arms programming. The next write of any value raises a request with op 0 and that write's address and data, and the mode becomes busy.
- R4: Unlock pair, 80h at 555h, a second unlock pair, then 10h at 555h raises op 1 (chip erase). This sets every bit of `erase_set_o` and makes the mode busy.
- R5: The same five opening cycles followed by 30h at any address open the sector window. The selected sector is the address's top `SECT_W` bits, and its bit is set in `erase_set_o`. Each further 30h write adds a sector and restarts the window. After `CLK_MHZ*WINDOW_US` write-free cycles, op 2 (sector erase) is raised.
- R6: In the window, a write other than 30h or B0h closes the window, clears `erase_set_o` and returns to array read without an erase request.
- R7: F0h in array read, within a sequence, in autoselect or in the window raises op 6 (reset) and returns to the base mode. In the erase-suspended idle state, F0h is ignored.
- R8: While a program or erase runs, writes have no effect. The exception is F0h with `op_timeout_i` high: it raises op 6, returns to array read, clears `erase_set_o` and drops the suspended state.
- R9: B0h during a running sector erase raises op 3 and enters erase-suspended. B0h in the window closes it and enters erase-suspended with no request. B0h is ignored during chip erase and programming.
- R10: 30h in the erase-suspended idle state raises op 4 (resume) and makes the mode busy. If the suspend happened in the window, it raises op 2 instead. Further 30h writes, and 30h in array read, are ignored.
- R11: While suspended, programming and autoselect are accepted. Program completion and F0h in autoselect return to erase-suspended. An erase setup (80h) is rejected.
- R12: The unlock pair and 90h at 555h raise op 5 and enter autoselect. The block stays there, ignoring all writes except F0h.
- R13: `op_done_i` ends a running operation. A program returns to the base mode; an erase returns to array read and clears `erase_set_o`. `op_done_i` takes precedence over a write in the same cycle, and has no effect when nothing runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | One latched bus write this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| op_done_i | input | 1 | Embedded operation finished |
| op_timeout_i | input | 1 | Embedded operation exceeded its time limit |
| mode_o | output | 2 | Operating mode |
| req_valid_o | output | 1 | Request strobe, one cycle |
| req_op_o | output | 3 | Requested operation |
| req_addr_o | output | ADDR_W | Program address |
| req_data_o | output | 8 | Program data |
| erase_set_o | output | 2**SECT_W | Sectors selected for erase |

## Verification
On every cycle, the assertions check the filtering rules while an operation runs. A reset or suspend write must not disturb a running program or chip erase. A program write must turn into a request with its own address and data. An expiring window must raise a sector-erase request, and the erase set may only grow inside the window. The resume strobe must coincide with the busy mode. Only the bench scenarios can show whole sequences end to end, because each spans several writes. These include exact window lengths with restarts, the suspend context across nested program and autoselect, the choice between a resume request and a deferred sector-erase start, and the precedence of completion over a simultaneous write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BUSY    = 2'd2,
    MODE_SUSP    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    OP_PROGRAM    = 3'd0,
    OP_CHIP_ERASE = 3'd1,
    OP_SECT_ERASE = 3'd2,
    OP_SUSPEND    = 3'd3,
    OP_RESUME     = 3'd4,
    OP_AUTOSEL    = 3'd5,
    OP_RESET      = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PSETUP,
    ST_ESETUP, ST_EUNL1, ST_EUNL2, ST_AUTOSEL,
    ST_WINDOW, ST_BUSY_PROG, ST_BUSY_CHIP, ST_BUSY_SECT,
    ST_SUSP
  } state_e;

  localparam logic [7:0] BYTE_UNL1   = 8'hAA;
  localparam logic [7:0] BYTE_UNL2   = 8'h55;
  localparam logic [7:0] BYTE_PROG   = 8'hA0;
  localparam logic [7:0] BYTE_ESETUP = 8'h80;
  localparam logic [7:0] BYTE_CHIP   = 8'h10;
  localparam logic [7:0] BYTE_SECT   = 8'h30;
  localparam logic [7:0] BYTE_ASEL   = 8'h90;
  localparam logic [7:0] BYTE_RESET  = 8'hF0;
  localparam logic [7:0] BYTE_SUSP   = 8'hB0;

  localparam logic [10:0] ADR_KEY_A = 11'h555;
  localparam logic [10:0] ADR_KEY_B = 11'h2AA;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic prog;
    logic esetup;
    logic chip;
    logic asel;
    logic d30;
    logic rst;
    logic susp;
  } wr_class_t;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import flash_cmd_pkg::*;
#(
  parameter int CMD_ADDR_W = 11
) (
  input  logic [CMD_ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]            data_i,
  output wr_class_t             cls_o
);
  localparam logic [CMD_ADDR_W-1:0] KEY_A = CMD_ADDR_W'(ADR_KEY_A);
  localparam logic [CMD_ADDR_W-1:0] KEY_B = CMD_ADDR_W'(ADR_KEY_B);

  logic at_a, at_b;

  always_comb begin
    at_a          = (cmd_addr_i == KEY_A);
    at_b          = (cmd_addr_i == KEY_B);
    cls_o.unl1    = at_a && (data_i == BYTE_UNL1);
    cls_o.unl2    = at_b && (data_i == BYTE_UNL2);
    cls_o.prog    = at_a && (data_i == BYTE_PROG);
    cls_o.esetup  = at_a && (data_i == BYTE_ESETUP);
    cls_o.chip    = at_a && (data_i == BYTE_CHIP);
    cls_o.asel    = at_a && (data_i == BYTE_ASEL);
    cls_o.d30     = (data_i == BYTE_SECT);
    cls_o.rst     = (data_i == BYTE_RESET);
    cls_o.susp    = (data_i == BYTE_SUSP);
  end
endmodule

// File: rtl/fcs_window_timer.sv
module fcs_window_timer #(
  parameter int WIN_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= CNT_W'(WIN_CYC - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fcs_sector_set.sv
module fcs_sector_set #(
  parameter int SECT_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   fill_i,
  input  logic                   add_i,
  input  logic [SECT_W-1:0]      sel_i,
  output logic [(1<<SECT_W)-1:0] set_o
);
  localparam int NUM_SECT = 1 << SECT_W;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    logic hit;
    assign hit = add_i && (sel_i == SECT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     set_o[g] <= 1'b0;
      else if (fill_i) set_o[g] <= 1'b1;
      else if (clr_i)  set_o[g] <= hit;
      else if (hit)    set_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_W     = 3,
  parameter int CMD_ADDR_W = 11,
  parameter int CLK_MHZ    = 50,
  parameter int WINDOW_US  = 50
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   op_done_i,
  input  logic                   op_timeout_i,
  output logic [1:0]             mode_o,
  output logic                   req_valid_o,
  output logic [2:0]             req_op_o,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [7:0]             req_data_o,
  output logic [(1<<SECT_W)-1:0] erase_set_o
);
  localparam int WIN_CYC = CLK_MHZ * WINDOW_US;

  state_e    state_q, state_d;
  logic      susp_q, susp_d;     // suspended context
  logic      pend_q, pend_d;     // suspended before erase started
  wr_class_t cls;
  logic      win_expired;
  logic      rq_v;
  op_e       rq_op;
  logic      set_clr, set_fill, set_add, tmr_load;
  state_e    base_st;

  fcs_decode #(.CMD_ADDR_W(CMD_ADDR_W)) u_dec (
    .cmd_addr_i (wr_addr_i[CMD_ADDR_W-1:0]),
    .data_i     (wr_data_i),
    .cls_o      (cls)
  );

  fcs_window_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .run_i     (state_q == ST_WINDOW && !wr_valid_i),
    .expired_o (win_expired)
  );

  fcs_sector_set #(.SECT_W(SECT_W)) u_set (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (set_clr),
    .fill_i (set_fill),
    .add_i  (set_add),
    .sel_i  (wr_addr_i[ADDR_W-1 -: SECT_W]),
    .set_o  (erase_set_o)
  );

  assign base_st = susp_q ? ST_SUSP : ST_IDLE;

  always_comb begin
    state_d  = state_q;
    susp_d   = susp_q;
    pend_d   = pend_q;
    rq_v     = 1'b0;
    rq_op    = OP_RESET;
    set_clr  = 1'b0;
    set_fill = 1'b0;
    set_add  = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (wr_valid_i) begin
        if (cls.unl1)     state_d = ST_UNL1;
        else if (cls.rst) rq_v = 1'b1;
      end
      ST_SUSP: if (wr_valid_i) begin
        if (cls.unl1) state_d = ST_UNL1;
        else if (cls.d30) begin
          rq_v    = 1'b1;
          rq_op   = pend_q ? OP_SECT_ERASE : OP_RESUME;
          state_d = ST_BUSY_SECT;
          susp_d  = 1'b0;
          pend_d  = 1'b0;
        end
      end
      ST_UNL1, ST_ESETUP: if (wr_valid_i) begin
        if (cls.unl1 && state_q == ST_ESETUP) state_d = ST_EUNL1;
        else if (cls.unl2 && state_q == ST_UNL1) state_d = ST_UNL2;
        else begin
          state_d = base_st;
          rq_v    = cls.rst;
        end
      end
      ST_UNL2: if (wr_valid_i) begin
        if (cls.prog) state_d = ST_PSETUP;
        else if (cls.esetup && !susp_q) state_d = ST_ESETUP;
        else if (cls.asel) begin
          state_d = ST_AUTOSEL;
          rq_v    = 1'b1;
          rq_op   = OP_AUTOSEL;
        end else begin
          state_d = base_st;
          rq_v    = cls.rst;
        end
      end
      ST_PSETUP: if (wr_valid_i) begin
        state_d = ST_BUSY_PROG;
        rq_v    = 1'b1;
        rq_op   = OP_PROGRAM;
      end
      ST_EUNL1: if (wr_valid_i) begin
        if (cls.unl2) state_d = ST_EUNL2;
        else begin
          state_d = base_st;
          rq_v    = cls.rst;
        end
      end
      ST_EUNL2: if (wr_valid_i) begin
        if (cls.chip) begin
          state_d  = ST_BUSY_CHIP;
          set_fill = 1'b1;
          rq_v     = 1'b1;
          rq_op    = OP_CHIP_ERASE;
        end else if (cls.d30) begin
          state_d  = ST_WINDOW;
          set_clr  = 1'b1;
          set_add  = 1'b1;
          tmr_load = 1'b1;
        end else begin
          state_d = base_st;
          rq_v    = cls.rst;
        end
      end
      ST_AUTOSEL: if (wr_valid_i && cls.rst) begin
        state_d = base_st;
        rq_v    = 1'b1;
      end
      ST_WINDOW: begin
        if (wr_valid_i) begin
          if (cls.d30) begin
            set_add  = 1'b1;
            tmr_load = 1'b1;
          end else if (cls.susp) begin
            state_d = ST_SUSP;
            susp_d  = 1'b1;
            pend_d  = 1'b1;
          end else begin
            state_d = ST_IDLE;
            set_clr = 1'b1;
            rq_v    = cls.rst;
          end
        end else if (win_expired) begin
          state_d = ST_BUSY_SECT;
          rq_v    = 1'b1;
          rq_op   = OP_SECT_ERASE;
        end
      end
      ST_BUSY_PROG, ST_BUSY_CHIP, ST_BUSY_SECT: begin
        if (op_done_i) begin
          state_d = (state_q == ST_BUSY_PROG) ? base_st : ST_IDLE;
          set_clr = (state_q != ST_BUSY_PROG);
        end else if (wr_valid_i && cls.susp && state_q == ST_BUSY_SECT) begin
          state_d = ST_SUSP;
          susp_d  = 1'b1;
          rq_v    = 1'b1;
          rq_op   = OP_SUSPEND;
        end else if (wr_valid_i && cls.rst && op_timeout_i) begin
          state_d = ST_IDLE;
          susp_d  = 1'b0;
          pend_d  = 1'b0;
          set_clr = 1'b1;
          rq_v    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      susp_q      <= 1'b0;
      pend_q      <= 1'b0;
      req_valid_o <= 1'b0;
      req_op_o    <= '0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else begin
      state_q     <= state_d;
      susp_q      <= susp_d;
      pend_q      <= pend_d;
      req_valid_o <= rq_v;
      if (rq_v) begin
        req_op_o   <= rq_op;
        req_addr_o <= (rq_op == OP_PROGRAM) ? wr_addr_i : '0;
        req_data_o <= (rq_op == OP_PROGRAM) ? wr_data_i : '0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_AUTOSEL: mode_o = MODE_AUTOSEL;
      ST_WINDOW, ST_BUSY_PROG, ST_BUSY_CHIP, ST_BUSY_SECT: mode_o = MODE_BUSY;
      ST_SUSP:    mode_o = MODE_SUSP;
      default:    mode_o = susp_q ? MODE_SUSP : MODE_ARRAY;
    endcase
  end

  AST_PROG_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == ST_PSETUP && wr_valid_i) |=> (req_valid_o && req_op_o == OP_PROGRAM && req_addr_o == $past(wr_addr_i) && req_data_o == $past(wr_data_i))); // R3
  AST_CHIP_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == ST_EUNL2 && wr_valid_i && cls.chip) |=> (&erase_set_o && mode_o == MODE_BUSY)); // R4
  AST_WIN_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == ST_WINDOW && !wr_valid_i && win_expired) |=> (req_valid_o && req_op_o == OP_SECT_ERASE)); // R5
  AST_WIN_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == ST_WINDOW && wr_valid_i && cls.d30) |=> ((erase_set_o & $past(erase_set_o)) == $past(erase_set_o))); // R5
  AST_BUSY_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni) ((state_q == ST_BUSY_PROG || state_q == ST_BUSY_CHIP) && wr_valid_i && !op_done_i && !op_timeout_i) |=> (!req_valid_o && mode_o == MODE_BUSY)); // R8
  AST_CHIP_NO_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == ST_BUSY_CHIP && wr_valid_i && cls.susp && !op_done_i) |=> (mode_o == MODE_BUSY)); // R9
  AST_RESUME_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_valid_o && req_op_o == OP_RESUME) |-> (mode_o == MODE_BUSY)); // R10
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wv = 1'b0;
  logic [18:0] wa = '0;
  logic [7:0]  wd = '0;
  logic        done = 1'b0;
  logic        tmo = 1'b0;
  logic [1:0]  mode;
  logic        rv;
  logic [2:0]  rop;
  logic [18:0] raddr;
  logic [7:0]  rdata;
  logic [7:0]  eset;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.CLK_MHZ(1), .WINDOW_US(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wv), .wr_addr_i(wa),
    .wr_data_i(wd), .op_done_i(done), .op_timeout_i(tmo),
    .mode_o(mode), .req_valid_o(rv), .req_op_o(rop), .req_addr_o(raddr),
    .req_data_o(rdata), .erase_set_o(eset)
  );

  // reference model: command history queue plus a coarse mode number
  // k: 0 read/sequence, 1 autoselect, 2 window, 3 program, 4 chip, 5 sector, 6 suspended idle
  int qa[$];
  int qd[$];
  int k, left, e_op, e_addr, e_data;
  bit sctx, pend, e_rv;
  int mask;

  function automatic int lo(int a);
    return a & 'h7FF;
  endfunction

  function int classify();
    int n;
    n = qa.size();
    if (!(lo(qa[0]) == 'h555 && qd[0] == 'hAA)) return 0;
    if (n == 1) return 1;
    if (!(lo(qa[1]) == 'h2AA && qd[1] == 'h55)) return 0;
    if (n == 2) return 1;
    if (lo(qa[2]) != 'h555) return 0;
    if (qd[2] == 'hA0) return (n == 3) ? 1 : 2;
    if (qd[2] == 'h90) return 5;
    if (qd[2] != 'h80 || sctx) return 0;
    if (n == 3) return 1;
    if (!(lo(qa[3]) == 'h555 && qd[3] == 'hAA)) return 0;
    if (n == 4) return 1;
    if (!(lo(qa[4]) == 'h2AA && qd[4] == 'h55)) return 0;
    if (n == 5) return 1;
    if (qd[5] == 'h10 && lo(qa[5]) == 'h555) return 3;
    if (qd[5] == 'h30) return 4;
    return 0;
  endfunction

  function void kill();
    k = 0; sctx = 0; pend = 0; mask = 0; e_rv = 1; e_op = 6;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      k = 0; sctx = 0; pend = 0; mask = 0; left = 0; e_rv = 0;
      e_op = 0; e_addr = 0; e_data = 0;
      qa.delete(); qd.delete();
    end else begin
      int a, d, c, kb;
      a = int'(wa); d = int'(wd); kb = k;
      e_rv = 0;
      case (k)
        0, 6: if (wv) begin
          if (k == 6 && d == 'h30) begin
            e_rv = 1; e_op = pend ? 2 : 4; k = 5; sctx = 0; pend = 0;
          end else begin
            qa.push_back(a); qd.push_back(d);
            c = classify();
            if (c != 1) begin qa.delete(); qd.delete(); end
            case (c)
              0: begin
                k = sctx ? 6 : 0;
                if (d == 'hF0 && kb == 0) begin e_rv = 1; e_op = 6; end
              end
              1: k = 0;
              2: begin e_rv = 1; e_op = 0; e_addr = a; e_data = d; k = 3; end
              3: begin e_rv = 1; e_op = 1; mask = 'hFF; k = 4; end
              4: begin mask = 1 << (a >> 16); left = WIN; k = 2; end
              default: begin e_rv = 1; e_op = 5; k = 1; end
            endcase
          end
        end
        1: if (wv && d == 'hF0) begin e_rv = 1; e_op = 6; k = sctx ? 6 : 0; end
        2: if (wv) begin
          if (d == 'h30) begin mask = mask | (1 << (a >> 16)); left = WIN; end
          else if (d == 'hB0) begin k = 6; sctx = 1; pend = 1; end
          else begin k = 0; mask = 0; if (d == 'hF0) begin e_rv = 1; e_op = 6; end end
        end else begin
          left = left - 1;
          if (left == 0) begin e_rv = 1; e_op = 2; k = 5; end
        end
        3: if (done) k = sctx ? 6 : 0;
           else if (wv && d == 'hF0 && tmo) kill();
        4: if (done) begin k = 0; mask = 0; end
           else if (wv && d == 'hF0 && tmo) kill();
        default: if (done) begin k = 0; mask = 0; end
           else if (wv && d == 'hB0) begin k = 6; sctx = 1; e_rv = 1; e_op = 3; end
           else if (wv && d == 'hF0 && tmo) kill();
      endcase
    end
  end

  function int exp_mode();
    if (k == 1) return 1;
    if (k >= 2 && k <= 5) return 2;
    if (k == 6) return 3;
    return sctx ? 3 : 0;
  endfunction

  task automatic chk(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    chk(tag, int'(mode), exp_mode(), "mode");
    chk(tag, int'(rv), int'(e_rv), "req_valid");
    chk(tag, int'(eset), mask, "erase_set");
    if (rv && e_rv) begin
      chk(tag, int'(rop), e_op, "req_op");
      if (e_op == 0) begin
        chk(tag, int'(raddr), e_addr, "req_addr");
        chk(tag, int'(rdata), e_data, "req_data");
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wv = 1'b1; wa = 19'(a); wd = 8'(d);
    @(negedge clk); wv = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic unlock(int hi);
    wr(hi | 'h555, 'hAA);
    wr(hi | 'h2AA, 'h55);
  endtask

  task automatic erase_open(int sa);
    unlock(0); wr('h555, 'h80); unlock(0); wr(sa, 'h30);
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1", int'(mode), 0, "reset mode");
    chk("R1", int'(rv), 0, "reset req");
    chk("R1", int'(eset), 0, "reset set");
    @(negedge clk); rst_ni = 1'b1;
    idle(2);

    tag = "R2";
    unlock('h7_8000);
    wr('h555, 'hA0);
    wr('h4_1234, 'h3C);
    chk("R2", int'(rop), 0, "high unlock bits ignored");
    pulse_done();
    wr('h555, 'hAA); wr('h2AA, 'h56);
    chk("R2", int'(mode), 0, "bad unlock");
    chk("R2", int'(rv), 0, "bad unlock no req");
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'hA0);
    chk("R2", int'(mode), 0, "bad address");

    tag = "R7";
    wr('h555, 'hAA); wr('h123, 'hF0);
    chk("R7", int'(rv), 1, "reset mid-sequence");
    chk("R7", int'(rop), 6, "reset op");
    wr('h0, 'hF0);

    tag = "R3";
    unlock(0); wr('h555, 'hA0); wr('h5_0ABC, 'hF0);
    chk("R3", int'(raddr), 'h5_0ABC, "program addr");
    chk("R3", int'(rdata), 'hF0, "program data");
    chk("R3", int'(mode), 2, "program busy");
    tag = "R8";
    wr('h0, 'hF0); wr('h555, 'hAA);
    chk("R8", int'(mode), 2, "busy ignores writes");
    tag = "R9";
    wr('h0, 'hB0);
    chk("R9", int'(mode), 2, "suspend ignored in program");
    tag = "R13";
    pulse_done();
    chk("R13", int'(mode), 0, "program done");
    pulse_done();

    tag = "R4";
    unlock(0); wr('h555, 'h80); unlock(0); wr('h555, 'h10);
    chk("R4", int'(eset), 'hFF, "chip set");
    chk("R4", int'(rop), 1, "chip op");
    wr('h0, 'hB0);
    chk("R9", int'(mode), 2, "suspend ignored in chip erase");
    pulse_done();
    chk("R13", int'(eset), 0, "chip done clears");

    tag = "R5";
    erase_open('h2_0000);
    idle(2);
    wr('h5_0000, 'h30);
    idle(WIN - 1);
    chk("R5", int'(rv), 0, "window still open");
    idle(1);
    chk("R5", int'(rv), 1, "window expiry");
    chk("R5", int'(rop), 2, "sector op");
    chk("R5", int'(eset), 'h24, "sector set");
    @(negedge clk); done = 1'b1; wv = 1'b1; wd = 8'hB0;
    @(negedge clk); done = 1'b0; wv = 1'b0;
    chk("R13", int'(mode), 0, "done beats suspend");

    tag = "R6";
    erase_open('h1_0000); wr('h555, 'hA0);
    chk("R6", int'(eset), 0, "abort clears");
    chk("R6", int'(rv), 0, "abort no req");
    erase_open('h7_0000); wr('h0, 'hF0);
    chk("R6", int'(rop), 6, "abort with reset");

    tag = "R9";
    erase_open('h3_0000);
    idle(WIN + 1);
    wr('h0, 'hB0);
    chk("R9", int'(rop), 3, "suspend op");
    chk("R9", int'(mode), 3, "suspended");
    wr('h0, 'hF0);
    chk("R7", int'(rv), 0, "reset ignored when suspended");
    tag = "R11";
    unlock(0); wr('h555, 'hA0); wr('h0_0010, 'h5A);
    chk("R11", int'(mode), 2, "program in suspend");
    pulse_done();
    chk("R11", int'(mode), 3, "back to suspend");
    unlock(0); wr('h555, 'h90);
    chk("R11", int'(mode), 1, "autoselect in suspend");
    wr('h0, 'hF0);
    chk("R11", int'(mode), 3, "autoselect exit to suspend");
    unlock(0); wr('h555, 'h80);
    chk("R11", int'(mode), 3, "erase setup rejected");
    tag = "R10";
    wr('h0, 'h30);
    chk("R10", int'(rop), 4, "resume op");
    wr('h0, 'h30);
    chk("R10", int'(rv), 0, "extra resume");
    pulse_done();

    tag = "R9";
    erase_open('h6_0000);
    wr('h0, 'hB0);
    chk("R9", int'(rv), 0, "window suspend no req");
    idle(WIN + 2);
    chk("R9", int'(mode), 3, "window closed");
    wr('h0, 'h30);
    chk("R10", int'(rop), 2, "deferred start");
    pulse_done();
    wr('h0, 'h30);
    chk("R10", int'(rv), 0, "resume in array read");

    tag = "R12";
    unlock(0); wr('h555, 'h90);
    chk("R12", int'(rop), 5, "autoselect op");
    unlock(0); wr('h555, 'hA0);
    chk("R12", int'(mode), 1, "autoselect holds");
    wr('h0, 'hF0);
    chk("R12", int'(mode), 0, "autoselect exit");

    tag = "R8";
    erase_open('h4_0000);
    idle(WIN + 1);
    wr('h0, 'hB0);
    unlock(0); wr('h555, 'hA0); wr('h0_0001, 'h11);
    @(negedge clk); tmo = 1'b1;
    wr('h0, 'hF0);
    tmo = 1'b0;
    chk("R8", int'(rop), 6, "timeout reset");
    chk("R8", int'(mode), 0, "timeout drops suspend");
    chk("R8", int'(eset), 0, "timeout clears set");
    pulse_done();
    chk("R13", int'(mode), 0, "done while idle");

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule